// File: doc/BRIEF.md
# Dual Timer with Paired PWM Output

The block holds two identical load-and-count timers behind a simple register write/read strobe port. Each timer has a control/status word, a load value and a live counter. A timer counts up or down from its load value. When it passes its terminal value it raises a one-cycle generate pulse and latches an interrupt flag. It then either reloads and carries on, or stops. Software starts both timers in the same cycle through a start-both bit that either timer's control word accepts.

When both timers are configured for pulse-width operation, they drive a single active-high PWM output together. Timer 0 fixes the period and timer 1 fixes the high time: each pulse of timer 0 restarts timer 1 and opens a new high phase, and the pulse of timer 1 ends it. The cycle count of a timer is two more than its programmed span, so a full-scale high time cannot be reached. Every period keeps at least one low cycle. The bits for capture, cascade and capture-trigger are stored and read back only.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset every register of both timers reads zero, and the generate, interrupt and PWM outputs are low.
- R2: Timer 0 decodes control at 0x00, load at 0x04 and counter at 0x08, and timer 1 decodes the same three at 0x10, 0x14 and 0x18. Control bits are: 0 capture mode, 1 count down, 2 generate enable, 3 capture trigger, 4 auto-reload, 5 load, 6 interrupt enable, 7 run, 8 flag, 9 PWM, 10 start-both, 11 cascade. Control bits other than the flag read back as written, and writes to the counter address are ignored.
- R3: While the load bit is set, the counter holds the load value and does not count.
- R4: Counting down with auto-reload, the generate output pulses for exactly one cycle every load+2 cycles.
- R5: Counting up with auto-reload, the generate output pulses once every (2^W-1)-load+2 cycles, where W is the counter width.
- R6: Each expiry sets the flag (bit 8). The interrupt output is high while the flag and the interrupt enable are both set. Writing 1 to bit 8 clears the flag, and writing 0 leaves it unchanged.
- R7: Without auto-reload, a timer pulses once, then clears its run bit and holds its counter at the value it wrapped to (all ones when counting down).
- R8: A control write with bit 10 set, to either timer, sets the run bit of both timers at the same clock edge, so their counters move in lockstep.
- R9: The PWM output stays low unless both timers have capture mode clear and PWM, generate enable, auto-reload and run set with the load bit clear, and timer 0 has cascade clear.
- R10: In PWM operation the output period equals timer 0's cycle count, and the output is high for timer 1's cycle count (load1+2 counting down) when that is shorter.
- R11: When timer 1's count reaches or exceeds timer 0's, the output is high for one cycle less than the period, so a full-scale duty never occurs.
- R12: The generate output stays low while generate enable is clear or capture mode is set, but expiry still sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| gen_o | output | 2 | One-cycle generate pulse per timer |
| irq_o | output | 2 | Interrupt per timer, flag and enable |
| pwm_o | output | 1 | Active-high PWM output |

## Verification
The hardest situation to reach is the one where timer 1's count meets or exceeds timer 0's while PWM runs. The output would then be high all the time, except for the single forced low cycle after each period pulse. The stimulus first sets up a normal duty, with both timers preloaded under the load bit and started together through the start-both bit. It then rewrites only timer 1's load value while the pair keeps running. After a settling gap, the scoreboard measures the high width and period of each pulse. The one-shot stop is reached in a similar way, by starting a preloaded down-counter with auto-reload clear and reading back its run bit and frozen counter afterwards.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  localparam int CTRL_W   = 12;
  localparam int ADDR_W   = 5;
  localparam int B_MODE   = 0;
  localparam int B_DOWN   = 1;
  localparam int B_GENOE  = 2;
  localparam int B_CAPEN  = 3;
  localparam int B_RELOAD = 4;
  localparam int B_LOAD   = 5;
  localparam int B_IE     = 6;
  localparam int B_EN     = 7;
  localparam int B_FLAG   = 8;
  localparam int B_PWM    = 9;
  localparam int B_ENALL  = 10;
  localparam int B_CASC   = 11;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dtp_rst_sync.sv
module dtp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dtp_timer.sv
module dtp_timer
  import dtp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              load_we,
  input  logic [W-1:0]      load_wdata,
  input  logic              enall_set,
  input  logic              restart,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [W-1:0]      load_o,
  output logic [W-1:0]      cnt_o,
  output logic              pend_o,
  output logic              gen_o,
  output logic              irq_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [W-1:0]      load_q, cnt_q, cnt_d, term_val;
  logic              pend_q, pend_d, run, at_term;

  // Terminal value depends on direction; passing it wraps the counter.
  assign term_val = ctrl_q[B_DOWN] ? '0 : '1;
  assign run      = ctrl_q[B_EN] & ~ctrl_q[B_LOAD] & ~pend_q;
  assign at_term  = run & (cnt_q == term_val);

  // Counter next state: load bit, PWM restart, wrap cycle, counting.
  always_comb begin
    cnt_d  = cnt_q;
    pend_d = 1'b0;
    if (ctrl_q[B_LOAD] || restart) begin
      cnt_d = load_q;
    end else if (pend_q) begin
      if (ctrl_q[B_RELOAD]) cnt_d = load_q;
    end else if (ctrl_q[B_EN]) begin
      cnt_d  = ctrl_q[B_DOWN] ? cnt_q - ONE : cnt_q + ONE;
      pend_d = at_term;
    end
  end

  // Control next state: software write, one-shot stop, flag, start-both.
  always_comb begin
    ctrl_d = ctrl_q;
    if (pend_q && !ctrl_q[B_RELOAD]) ctrl_d[B_EN] = 1'b0;
    if (ctrl_we) begin
      ctrl_d         = ctrl_wdata;
      ctrl_d[B_FLAG] = ctrl_q[B_FLAG] & ~ctrl_wdata[B_FLAG];
    end
    if (pend_q)    ctrl_d[B_FLAG] = 1'b1;
    if (enall_set) ctrl_d[B_EN]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (load_we) load_q <= load_wdata;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
  assign gen_o  = pend_q & ctrl_q[B_GENOE] & ~ctrl_q[B_MODE];
  assign irq_o  = ctrl_q[B_FLAG] & ctrl_q[B_IE];
endmodule

// File: rtl/dtp_pwm.sv
module dtp_pwm
  import dtp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl0,
  input  logic [CTRL_W-1:0] ctrl1,
  input  logic              gen0,
  input  logic              gen1,
  output logic              active_o,
  output logic              restart1_o,
  output logic              pwm_o
);
  logic pwm_q, pwm_d, rise_q, rise_d;

  function automatic logic pwm_ready(input logic [CTRL_W-1:0] c);
    return ~c[B_MODE] & c[B_PWM] & c[B_GENOE] & c[B_RELOAD] & c[B_EN] & ~c[B_LOAD];
  endfunction

  assign active_o = pwm_ready(ctrl0) & pwm_ready(ctrl1) & ~ctrl0[B_CASC];

  // Period pulse: one forced low cycle, then rise and restart timer 1.
  assign rise_d     = active_o & gen0;
  assign restart1_o = active_o & rise_q;

  always_comb begin
    if (!active_o)   pwm_d = 1'b0;
    else if (gen0)   pwm_d = 1'b0;
    else if (rise_q) pwm_d = 1'b1;
    else if (gen1)   pwm_d = 1'b0;
    else             pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      pwm_q  <= pwm_d;
      rise_q <= rise_d;
    end
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
  import dtp_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        gen_o,
  output logic [1:0]        irq_o,
  output logic              pwm_o
);
  localparam int NT = 2;

  logic              rst_sync_n;
  logic [CTRL_W-1:0] ctrl_q [NT];
  logic [CNT_W-1:0]  load_q [NT];
  logic [CNT_W-1:0]  cnt_q  [NT];
  logic [NT-1:0]     ctrl_we, load_we, enall_wr, pend_v, restart_v;
  logic              pwm_active, pwm_restart;
  reg_sel_e          wr_sel, rd_sel;
  logic              wr_ok, rd_ok;

  dtp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_sel = reg_sel_e'(wr_addr[3:2]);
  assign rd_sel = reg_sel_e'(rd_addr[3:2]);
  assign wr_ok  = wr_en & (wr_addr[1:0] == 2'b00);
  assign rd_ok  = (rd_addr[1:0] == 2'b00);

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign ctrl_we[i]   = wr_ok & (wr_addr[4] == i[0]) & (wr_sel == SEL_CTRL);
    assign load_we[i]   = wr_ok & (wr_addr[4] == i[0]) & (wr_sel == SEL_LOAD);
    assign enall_wr[i]  = ctrl_we[i] & wr_data[B_ENALL];
    assign restart_v[i] = (i == 1) & pwm_restart;

    dtp_timer #(.W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ctrl_we    (ctrl_we[i]),
      .ctrl_wdata (wr_data[CTRL_W-1:0]),
      .load_we    (load_we[i]),
      .load_wdata (wr_data[CNT_W-1:0]),
      .enall_set  (|enall_wr),
      .restart    (restart_v[i]),
      .ctrl_o     (ctrl_q[i]),
      .load_o     (load_q[i]),
      .cnt_o      (cnt_q[i]),
      .pend_o     (pend_v[i]),
      .gen_o      (gen_o[i]),
      .irq_o      (irq_o[i])
    );
  end

  dtp_pwm u_pwm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctrl0      (ctrl_q[0]),
    .ctrl1      (ctrl_q[1]),
    .gen0       (gen_o[0]),
    .gen1       (gen_o[1]),
    .active_o   (pwm_active),
    .restart1_o (pwm_restart),
    .pwm_o      (pwm_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      unique case (rd_sel)
        SEL_CTRL: rd_data[CTRL_W-1:0] = ctrl_q[rd_addr[4]];
        SEL_LOAD: rd_data[CNT_W-1:0]  = load_q[rd_addr[4]];
        SEL_CNT:  rd_data[CNT_W-1:0]  = cnt_q[rd_addr[4]];
        default:  rd_data             = '0;
      endcase
    end
  end
endmodule

// File: rtl/dtp_checker.sv
module dtp_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         any_wr,
  input logic         enall_wr,
  input logic         ld0,
  input logic         flag0,
  input logic         reload0,
  input logic         en0,
  input logic         en1,
  input logic [W-1:0] cnt0,
  input logic [W-1:0] load0,
  input logic         pend0,
  input logic         gen0,
  input logic         active,
  input logic         pwm
);
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    ld0 |=> cnt0 == $past(load0)); // R3

  AST_GEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    gen0 |=> !gen0); // R4

  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    pend0 |=> flag0); // R6

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    pend0 && !reload0 && !any_wr |=> !en0); // R7

  AST_ENALL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    enall_wr |=> en0 && en1); // R8

  AST_PWM_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pwm); // R9

  AST_PWM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && $past(gen0) |=> pwm); // R10

  AST_NO_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    active && gen0 |=> !pwm); // R11
endmodule

bind dual_timer_pwm dtp_checker #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .any_wr   (wr_en),
  .enall_wr (|enall_wr),
  .ld0      (ctrl_q[0][dtp_pkg::B_LOAD]),
  .flag0    (ctrl_q[0][dtp_pkg::B_FLAG]),
  .reload0  (ctrl_q[0][dtp_pkg::B_RELOAD]),
  .en0      (ctrl_q[0][dtp_pkg::B_EN]),
  .en1      (ctrl_q[1][dtp_pkg::B_EN]),
  .cnt0     (cnt_q[0]),
  .load0    (load_q[0]),
  .pend0    (pend_v[0]),
  .gen0     (gen_o[0]),
  .active   (pwm_active),
  .pwm      (pwm_o)
);

// File: tb/tb_dual_timer_pwm.sv
module tb_dual_timer_pwm;
  localparam int W = 32;
  localparam logic [31:0] C_MODE = 32'h001, C_DOWN = 32'h002, C_GEN = 32'h004,
    C_CAPEN = 32'h008, C_RELOAD = 32'h010, C_LOAD = 32'h020, C_IE = 32'h040,
    C_EN = 32'h080, C_FLAG = 32'h100, C_PWM = 32'h200, C_ENALL = 32'h400,
    C_CASC = 32'h800;
  localparam logic [31:0] PWMSET = C_DOWN | C_GEN | C_RELOAD | C_PWM;

  logic        clk = 1'b0;
  logic        rst_n, wr_en;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  gen_o, irq_o;
  logic        pwm_o;

  dual_timer_pwm #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .gen_o(gen_o), .irq_o(irq_o), .pwm_o(pwm_o)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard: stream 0 gen0 gap, 1 PWM high width, 2 PWM period.
  int    q_gap [3][$];
  string q_tag [3][$];
  int    last_t [3];
  bit    have_t [3];
  int    rise_t = 0, gen0_cnt = 0, rise_cnt = 0;
  bit    have_rise = 0;
  logic  pwm_prev = 1'b0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sb_cmp(int s, int gap);
    if (q_gap[s].size() > 0) begin
      int e = q_gap[s].pop_front();
      string t = q_tag[s].pop_front();
      check(t, gap, e);
    end
  endtask

  task automatic sb_evt(int s, int t);
    if (have_t[s]) sb_cmp(s, t - last_t[s]);
    last_t[s] = t;
    have_t[s] = 1'b1;
  endtask

  task automatic sb_arm();
    for (int s = 0; s < 3; s++) have_t[s] = 1'b0;
    have_rise = 1'b0;
  endtask

  task automatic sb_push(int s, string tag, int gap, int n);
    for (int k = 0; k < n; k++) begin
      q_gap[s].push_back(gap);
      q_tag[s].push_back(tag);
    end
  endtask

  task automatic sb_drain(string tag);
    int left;
    for (int k = 0; k < 600; k++) begin
      if (q_gap[0].size() + q_gap[1].size() + q_gap[2].size() == 0) break;
      @(negedge clk);
    end
    left = q_gap[0].size() + q_gap[1].size() + q_gap[2].size();
    if (left != 0) begin
      checks++;
      errors++;
      $display("FAIL %s: actual=%0d pending events expected=0", tag, left);
      for (int s = 0; s < 3; s++) begin
        q_gap[s].delete();
        q_tag[s].delete();
      end
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (gen_o[0] === 1'b1) begin
        gen0_cnt++;
        sb_evt(0, cyc);
      end
      if (pwm_o === 1'b1 && pwm_prev === 1'b0) begin
        rise_cnt++;
        sb_evt(2, cyc);
        rise_t    = cyc;
        have_rise = 1'b1;
      end
      if (pwm_o === 1'b0 && pwm_prev === 1'b1 && have_rise) sb_cmp(1, cyc - rise_t);
    end
    pwm_prev = pwm_o;
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0, c1;
    int g, r;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    begin
      logic [4:0] addrs [6] = '{5'h00, 5'h04, 5'h08, 5'h10, 5'h14, 5'h18};
      foreach (addrs[k]) begin
        rd(addrs[k], v);
        check("R1 register zero", v, 0);
      end
    end
    check("R1 gen low", gen_o, 0);
    check("R1 irq low", irq_o, 0);
    check("R1 pwm low", pwm_o, 0);

    // R2 map, read-back, counter write ignored
    wr(5'h10, C_MODE | C_CAPEN | C_IE | C_CASC);
    rd(5'h10, v); check("R2 ctrl1 readback", v, 32'h849);
    wr(5'h14, 32'h1234);
    rd(5'h14, v); check("R2 load1 readback", v, 32'h1234);
    wr(5'h18, 32'hdead);
    rd(5'h18, v); check("R2 counter write ignored", v, 0);
    wr(5'h10, 32'h0);

    // R3 load bit holds counter
    wr(5'h04, 5);
    wr(5'h00, C_LOAD | C_DOWN);
    repeat (5) @(negedge clk);
    rd(5'h08, v); check("R3 counter equals load", v, 5);
    repeat (5) @(negedge clk);
    rd(5'h08, v); check("R3 counter not running", v, 5);

    // R4 down period load+2
    sb_arm();
    sb_push(0, "R4 down gap", 7, 3);
    wr(5'h00, C_DOWN | C_GEN | C_RELOAD | C_EN | C_IE);
    sb_drain("R4 drain");
    wr(5'h00, C_DOWN | C_GEN | C_RELOAD | C_IE);
    rd(5'h00, v); check("R6 flag set", (v >> 8) & 1, 1);
    check("R6 irq high", irq_o[0], 1);
    wr(5'h00, C_IE | C_FLAG);
    rd(5'h00, v); check("R6 flag cleared by write 1", v, 32'h040);
    check("R6 irq low after clear", irq_o[0], 0);

    // R5 up period (2^W-1)-load+2
    wr(5'h04, 32'hFFFF_FFEF);
    wr(5'h00, C_LOAD);
    sb_arm();
    sb_push(0, "R5 up gap", 18, 2);
    wr(5'h00, C_GEN | C_RELOAD | C_EN);
    sb_drain("R5 drain");
    wr(5'h00, C_FLAG);

    // R12 generate gated
    wr(5'h04, 5);
    wr(5'h00, C_LOAD | C_DOWN);
    g = gen0_cnt;
    wr(5'h00, C_DOWN | C_RELOAD | C_EN);
    repeat (30) @(negedge clk);
    check("R12 no gen without enable", gen0_cnt, g);
    rd(5'h00, v); check("R12 flag still set", (v >> 8) & 1, 1);
    wr(5'h00, C_MODE | C_DOWN | C_GEN | C_RELOAD | C_EN);
    repeat (30) @(negedge clk);
    check("R12 no gen in capture mode", gen0_cnt, g);
    wr(5'h00, C_FLAG);

    // R7 one-shot
    wr(5'h04, 3);
    wr(5'h00, C_LOAD | C_DOWN);
    g = gen0_cnt;
    wr(5'h00, C_DOWN | C_GEN | C_EN);
    repeat (20) @(negedge clk);
    check("R7 single pulse", gen0_cnt, g + 1);
    rd(5'h00, v); check("R7 run bit cleared", (v >> 7) & 1, 0);
    rd(5'h08, c0); check("R7 counter held", c0, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    rd(5'h08, c0); check("R7 counter still held", c0, 32'hFFFF_FFFF);
    wr(5'h00, C_FLAG);

    // R8 start-both lockstep
    wr(5'h04, 100);
    wr(5'h14, 100);
    wr(5'h00, C_LOAD | C_DOWN);
    wr(5'h10, C_LOAD | C_DOWN);
    wr(5'h00, C_DOWN);
    wr(5'h10, C_DOWN);
    wr(5'h10, C_DOWN | C_ENALL);
    rd(5'h00, v); check("R8 timer0 run", (v >> 7) & 1, 1);
    rd(5'h10, v); check("R8 timer1 run", (v >> 7) & 1, 1);
    rd(5'h08, c0);
    rd(5'h18, c1);
    check("R8 lockstep counters", c1, c0 - 1);
    wr(5'h00, C_FLAG);
    wr(5'h10, C_FLAG);

    // R10 PWM waveform
    wr(5'h04, 8);
    wr(5'h14, 3);
    wr(5'h00, C_LOAD | C_DOWN);
    wr(5'h10, C_LOAD | C_DOWN);
    sb_arm();
    sb_push(1, "R10 high width", 5, 3);
    sb_push(2, "R10 period", 10, 2);
    wr(5'h00, PWMSET);
    wr(5'h10, PWMSET | C_ENALL);
    sb_drain("R10 drain");

    // R11 duty beyond period
    wr(5'h14, 20);
    repeat (25) @(negedge clk);
    sb_arm();
    sb_push(1, "R11 high width", 9, 2);
    sb_push(2, "R11 period", 10, 2);
    sb_drain("R11 drain");

    // R9 enable conditions
    r = rise_cnt;
    wr(5'h10, C_DOWN | C_GEN | C_RELOAD | C_EN);
    repeat (30) @(negedge clk);
    check("R9 no rise without PWM bit", rise_cnt, r);
    check("R9 output low without PWM bit", pwm_o, 0);
    wr(5'h10, PWMSET | C_EN);
    repeat (30) @(negedge clk);
    check("R9 rises when restored", rise_cnt > r, 1);
    wr(5'h00, PWMSET | C_EN | C_CASC);
    repeat (2) @(negedge clk);
    r = rise_cnt;
    repeat (30) @(negedge clk);
    check("R9 no rise with cascade", rise_cnt, r);
    check("R9 output low with cascade", pwm_o, 0);

    finish_run();
  end
endmodule